// File: doc/BRIEF.md
# Wide Modular Adder-Subtractor

This block adds or subtracts two wide operands modulo a value held in its own modulus register. The modulus is loaded through an indexed register write port, and only one index selects the modulus. Each operation is issued with a one-cycle strobe that carries an add/subtract select and two operands. One cycle later the block presents the reduced result together with a one-cycle done pulse.

The reduction always takes the same path. For an add, the block forms the full sum one bit wider than the operands and also forms the sum minus the modulus. For a subtract, it forms the plain difference and also the difference plus the modulus. The final result is then chosen by a multiplexer. Cycle count and datapath activity are therefore the same whether or not the correction is applied.

Operands are expected to be below the modulus already; what happens with larger operands is not defined. Both stream edges are fire-and-forget. There is no ready signal, so an operation may be issued every cycle, and the consumer must take each result in the cycle its done pulse is high. The result stays on the output until the next operation completes.

Top module: `modaddsub`

## Requirements
- R1: After reset, `out_valid` is 0, `out_result` is 0 and the stored modulus is 0. Before any modulus write, a subtract of 3 minus 5 therefore returns 2^W - 2.
- R2: An operation with `in_sub` = 0 whose sum a + b is below the modulus m returns a + b.
- R3: An operation with `in_sub` = 0 whose sum is m or more returns a + b - m. This includes the case where a + b carries out of the top operand bit, and the result is then below m.
- R4: An operation with `in_sub` = 1 and a >= b returns a - b.
- R5: An operation with `in_sub` = 1 and a < b returns a - b + m, taken in W bits.
- R6: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and at no other time. This latency does not depend on the data. `out_result` keeps its value in every cycle that follows a cycle without `in_valid`.
- R7: A write with `mod_we` = 1 loads `mod_wdata` into the modulus only when `mod_idx` equals 0. A write at any other index leaves the modulus unchanged.
- R8: An operation issued in the same cycle as a modulus write uses the modulus held before that write. The new modulus applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_we | input | 1 | Register write strobe |
| mod_idx | input | IDX_W | Register index; 0 selects the modulus |
| mod_wdata | input | W | Register write data |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 = modular add, 1 = modular subtract |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Done pulse, one cycle after the strobe |
| out_result | output | W | Reduced result |

## Verification
The bench builds the block with its default parameters: W = 256, IDX_W = 3 and the modulus at index 0. At full width, moduli close to 2^256 make a sum that carries out of bit 255 easy to reach, which is the case the wide sum exists for. Small moduli such as 1 and 97 cover the boundary where the sum equals the modulus exactly and the case where every result collapses to zero. A per-clock behavioural model tracks the modulus as it is written and predicts the done pulse and the result. It also covers back-to-back strobes, writes at other indices, and writes that coincide with an operation.

// File: rtl/mam_pkg.sv
package mam_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } mam_op_e;

  localparam int unsigned MAM_MOD_INDEX = 0;
endpackage

// File: rtl/mam_modreg.sv
module mam_modreg #(
  parameter int unsigned W       = 256,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned SEL_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     modulus
);
  localparam logic [IDX_W-1:0] SEL = IDX_W'(SEL_IDX);

  logic hit;
  assign hit = we && (idx == SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   modulus <= '0;
    else if (hit) modulus <= wdata;
  end
endmodule

// File: rtl/mam_raw.sv
module mam_raw #(
  parameter int unsigned W = 256
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum,
  output logic [W:0]   diff
);
  // Sum keeps its carry in bit W; difference keeps its borrow in bit W.
  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};
endmodule

// File: rtl/mam_fix.sv
module mam_fix #(
  parameter int unsigned W = 256
) (
  input  mam_pkg::mam_op_e op,
  input  logic [W:0]       sum,
  input  logic [W:0]       diff,
  input  logic [W-1:0]     modulus,
  output logic [W-1:0]     result
);
  localparam int unsigned XW = W + 2;

  logic [XW-1:0] add_trial;
  logic          add_keep;
  logic [W-1:0]  sub_trial;
  logic          sub_borrow;
  logic [W-1:0]  add_res;
  logic [W-1:0]  sub_res;

  // Both correction candidates are always formed, whatever the data.
  assign add_trial  = {1'b0, sum} - {2'b00, modulus};
  assign add_keep   = add_trial[XW-1];
  assign sub_borrow = diff[W];
  assign sub_trial  = diff[W-1:0] + modulus;

  assign add_res = add_keep   ? sum[W-1:0] : add_trial[W-1:0];
  assign sub_res = sub_borrow ? sub_trial  : diff[W-1:0];

  always_comb begin
    unique case (op)
      mam_pkg::OP_SUB: result = sub_res;
      default:         result = add_res;
    endcase
  end
endmodule

// File: rtl/modaddsub.sv
module modaddsub #(
  parameter int unsigned W       = 256,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned MOD_IDX = mam_pkg::MAM_MOD_INDEX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_we,
  input  logic [IDX_W-1:0] mod_idx,
  input  logic [W-1:0]     mod_wdata,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  output logic [W-1:0]     out_result
);
  logic [W-1:0]     mod_q;
  logic [W:0]       sum_w;
  logic [W:0]       diff_w;
  logic [W-1:0]     fixed;
  mam_pkg::mam_op_e op;

  assign op = in_sub ? mam_pkg::OP_SUB : mam_pkg::OP_ADD;

  mam_modreg #(.W(W), .IDX_W(IDX_W), .SEL_IDX(MOD_IDX)) u_modreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mod_we),
    .idx     (mod_idx),
    .wdata   (mod_wdata),
    .modulus (mod_q)
  );

  mam_raw #(.W(W)) u_raw (
    .a    (in_a),
    .b    (in_b),
    .sum  (sum_w),
    .diff (diff_w)
  );

  mam_fix #(.W(W)) u_fix (
    .op      (op),
    .sum     (sum_w),
    .diff    (diff_w),
    .modulus (mod_q),
    .result  (fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= fixed;
    end
  end
endmodule

// File: rtl/mam_checker.sv
module mam_checker #(
  parameter int unsigned W       = 256,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned MOD_IDX = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_we,
  input logic [IDX_W-1:0] mod_idx,
  input logic [W-1:0]     mod_wdata,
  input logic             in_valid,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic             out_valid,
  input logic [W-1:0]     out_result,
  input logic [W-1:0]     mod_q
);
  localparam logic [IDX_W-1:0] SEL = IDX_W'(MOD_IDX);

  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_done_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  p_mod_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_we && mod_idx == SEL) |=> (mod_q == $past(mod_wdata)));

  p_mod_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_we && mod_idx == SEL) |=> $stable(mod_q));

  p_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a < mod_q && in_b < mod_q) |=> (out_result < $past(mod_q)));
endmodule

bind modaddsub mam_checker #(.W(W), .IDX_W(IDX_W), .MOD_IDX(MOD_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_we     (mod_we),
  .mod_idx    (mod_idx),
  .mod_wdata  (mod_wdata),
  .in_valid   (in_valid),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_result (out_result),
  .mod_q      (mod_q)
);

// File: tb/tb_modaddsub.sv
`timescale 1ns/1ps
module tb_modaddsub;
  localparam int unsigned W     = 256;
  localparam int unsigned IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mod_we = 1'b0;
  logic [IDX_W-1:0] mod_idx = '0;
  logic [W-1:0]     mod_wdata = '0;
  logic             in_valid = 1'b0;
  logic             in_sub = 1'b0;
  logic [W-1:0]     in_a = '0;
  logic [W-1:0]     in_b = '0;
  logic             out_valid;
  logic [W-1:0]     out_result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string focus = "";

  always #2 clk = ~clk;

  modaddsub #(.W(W), .IDX_W(IDX_W), .MOD_IDX(0)) dut (
    .clk(clk), .rst_n(rst_n), .mod_we(mod_we), .mod_idx(mod_idx),
    .mod_wdata(mod_wdata), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  // Behavioural reference model, advanced on every clock.
  logic [W-1:0] m_mod;
  logic         m_valid;
  logic [W-1:0] m_res;
  string        m_tag;

  function automatic logic [W-1:0] ref_calc(input logic sub, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W+1:0] s;
    if (!sub) begin
      s = W'(0) + a;
      s = s + b;
      if (s >= m) s = s - m;
    end else if (a >= b) begin
      s = a - b;
    end else begin
      s = W'(0) + a;
      s = s + m - b;
    end
    return s[W-1:0];
  endfunction

  function automatic string ref_tag(input logic sub, input logic [W-1:0] a,
                                    input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W+1:0] s;
    s = W'(0) + a;
    s = s + b;
    if (!sub) return (s >= m) ? "R3" : "R2";
    return (a >= b) ? "R4" : "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mod <= '0; m_valid <= 1'b0; m_res <= '0; m_tag <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_res <= ref_calc(in_sub, in_a, in_b, m_mod);
        m_tag <= (focus != "") ? focus : ref_tag(in_sub, in_a, in_b, m_mod);
      end
      if (mod_we && mod_idx == 0) m_mod <= mod_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, m_valid);
      end
      checks++;
      if (out_result !== m_res) begin
        errors++;
        $display("FAIL %s out_result actual=%h expected=%h", m_tag, out_result, m_res);
      end
    end
  end

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic idle(input int n);
    in_valid = 1'b0; mod_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [IDX_W-1:0] idx, input logic [W-1:0] v);
    mod_we = 1'b1; mod_idx = idx; mod_wdata = v; in_valid = 1'b0;
    @(negedge clk);
    mod_we = 1'b0;
  endtask

  // Issues one operation; leaves in_valid high for back-to-back use.
  task automatic op(input logic sub, input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = 1'b1; in_sub = sub; in_a = a; in_b = b;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] m;
    logic [W-1:0] big;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", out_valid, out_result);
    end
    // R1: modulus reset to zero, so 3-5 wraps to 2^W-2
    focus = "R1"; op(1'b1, 3, 5); idle(2); focus = "";

    // Small modulus 97: R2..R5 and the equality boundary of R3
    wr(0, 97);
    op(1'b0, 10, 20);
    op(1'b0, 60, 50);
    op(1'b0, 96, 1);
    op(1'b1, 50, 20);
    op(1'b1, 20, 50);
    op(1'b1, 0, 96);
    idle(2);

    // R6: back-to-back operations, then a gap
    for (int i = 0; i < 8; i++) op(i[0], W'(i * 11 % 97), W'(i * 7 % 97));
    idle(3);

    // Large modulus near 2^W: sum carries out of the top bit (R3)
    big = {W{1'b1}} - W'(188);
    wr(0, big);
    op(1'b0, big - 1, big - 2);
    op(1'b0, big - 1, 1);
    op(1'b1, 1, big - 1);
    op(1'b0, {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
    idle(2);

    // R7: write at other indices must not touch the modulus
    wr(3, 5);
    wr(1, 7);
    focus = "R7"; op(1'b0, big - 1, big - 3); idle(2); focus = "";

    // R8: write coinciding with an operation uses the old modulus
    mod_we = 1'b1; mod_idx = 0; mod_wdata = 13;
    focus = "R8"; op(1'b0, 100, 200);
    mod_we = 1'b0;
    op(1'b0, 7, 9);
    idle(2); focus = "";

    // Modulus 1: every result collapses to zero
    wr(0, 1);
    op(1'b0, 0, 0); op(1'b1, 0, 0);
    idle(2);

    // Random moduli and operands below them
    for (int k = 0; k < 40; k++) begin
      m = rnd();
      if (k % 4 == 1) m = m >> (k % 200);
      if (m == 0) m = 1;
      wr(0, m);
      for (int j = 0; j < 8; j++) op($urandom_range(0, 1), rnd() % m, rnd() % m);
      idle(1);
    end

    idle(3);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule